// File: doc/BRIEF.md
# Host-Port Breakpoint and Interrupt Router

This block lives between an embedded CPU, an external host port and ten interrupt lines coming from the interface engines. It holds two 16-bit words that the host can read and write. The CPU may read both but cannot change them. The first word is a breakpoint address. When the CPU program counter equals a non-zero breakpoint address, a sticky breakpoint interrupt is raised toward the CPU. The host clears that interrupt by writing zero to the word, and the same write disarms the breakpoint.

The second word is a steering map. Each bit decides whether an interface-engine interrupt reaches the host interrupt line, the CPU interrupt vector, or both. Eight sources have only a host bit: setting it moves the source from the CPU to the host. The two frame-marker sources each have their own pair of bits, one for the host and one for the CPU, and the two bits act independently. Every source that is steered to the host is ORed into one host interrupt line. The same sources also appear in a status word that only the host can read. Both sides read their data combinationally from a word-addressed register bus. Writes take effect at the next clock edge.

Top module: `hpbr_top`

## Requirements
- R1: After reset the breakpoint word reads 0x0000, the steering word reads 0x1400 and `bkpt_irq` is low.
- R2: A host write takes effect at the next rising edge and the read data follows the address in the same cycle. Word offsets are 0 for the breakpoint word, 1 for the steering word and 2 for the host status word. Steering bits 5 and 4 always read as zero. Bits 8 and 0 are plain storage bits with no routing effect.
- R3: A CPU write to any offset leaves both words unchanged. CPU reads of offsets 0 and 1 return the same values the host sees.
- R4: If the breakpoint word is non-zero and `cpu_pc` equals it at a rising edge, `bkpt_irq` is high from that edge on. It stays high after `cpu_pc` moves away.
- R5: A host write of 0x0000 to the breakpoint word drops `bkpt_irq` at that edge. After that write, `cpu_pc` = 0 raises no interrupt.
- R6: A host write of a non-zero value to the breakpoint word does not clear a pending breakpoint interrupt.
- R7: Source vector bit order is 0 reset1, 1 done1, 2 done2, 3 resume1, 4 resume2, 5 reset2, 6 sof1, 7 sof2, 8 id, 9 vbus. The single steering bits are 1, 2, 3, 6, 7, 9, 14 and 15, one for each of those sources in that order. When such a bit is 1 the active source goes to the host and is masked from `cpu_irq`. When it is 0 the source goes to `cpu_irq` only.
- R8: Steering bits 11 (host) and 10 (CPU) control sof1, and bits 13 (host) and 12 (CPU) control sof2. Each bit of a pair gates its own path, so a source can go to both sides, to either side, or to neither.
- R9: The status word (offset 2) shows each host-steered active source at the position of its host steering bit. `host_irq` is the OR of those bits.
- R10: Offset 3 reads zero on both sides, and the status word reads zero on the CPU side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Host word offset |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| cpu_addr | input | 2 | CPU word offset |
| cpu_wr | input | 1 | CPU write strobe (ignored) |
| cpu_wdata | input | 16 | CPU write data (ignored) |
| cpu_rdata | output | 16 | CPU read data, combinational |
| cpu_pc | input | 16 | CPU program counter |
| src_irq | input | 10 | Interface-engine interrupt sources |
| cpu_irq | output | 10 | Interrupts delivered to the CPU |
| host_irq | output | 1 | Host interrupt line |
| bkpt_irq | output | 1 | Sticky breakpoint interrupt to the CPU |

## Verification
Read data, `cpu_irq`, `host_irq` and the status word depend combinationally on the stored words and `src_irq`. The bench therefore samples them 1 ns after changing an input, with no clock edge in between. Register writes and breakpoint matches pass through exactly one flop. For these, the bench drives at a falling edge, lets one rising edge pass and samples at the next falling edge. It also checks the value before that edge, to show the effect is not early.

// File: rtl/hpbr_pkg.sv
package hpbr_pkg;
  localparam int DATA_W = 16;
  localparam int NSRC   = 10;

  localparam logic [1:0] OFS_BKPT  = 2'd0;
  localparam logic [1:0] OFS_ROUTE = 2'd1;
  localparam logic [1:0] OFS_STAT  = 2'd2;

  localparam logic [DATA_W-1:0] ROUTE_RST   = 16'h1400;
  localparam logic [DATA_W-1:0] ROUTE_WMASK = 16'hFFCF;

  typedef enum int {
    S_RESET1 = 0, S_DONE1 = 1, S_DONE2 = 2, S_RESUME1 = 3, S_RESUME2 = 4,
    S_RESET2 = 5, S_SOF1 = 6, S_SOF2 = 7, S_ID = 8, S_VBUS = 9
  } src_e;

  // steering-word position of each source's host bit
  function automatic int host_pos(input int s);
    case (s)
      S_RESET1:  host_pos = 1;
      S_DONE1:   host_pos = 2;
      S_DONE2:   host_pos = 3;
      S_RESUME1: host_pos = 6;
      S_RESUME2: host_pos = 7;
      S_RESET2:  host_pos = 9;
      S_SOF1:    host_pos = 11;
      S_SOF2:    host_pos = 13;
      S_ID:      host_pos = 14;
      default:   host_pos = 15;
    endcase
  endfunction

  function automatic bit has_cpu_bit(input int s);
    has_cpu_bit = (s == S_SOF1) || (s == S_SOF2);
  endfunction

  // position of the separate CPU bit (valid only where has_cpu_bit)
  function automatic int cpu_pos(input int s);
    cpu_pos = host_pos(s) - 1;
  endfunction

  function automatic logic bp_hit(input logic [DATA_W-1:0] bp,
                                  input logic [DATA_W-1:0] pc);
    bp_hit = (bp != '0) && (bp == pc);
  endfunction
endpackage

// File: rtl/hpbr_bkpt_unit.sv
module hpbr_bkpt_unit
  import hpbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cpu_wr_hit,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] bp_addr,
  output logic              match,
  output logic              clr_evt,
  output logic              irq
);
  logic [DATA_W-1:0] bp_q;
  logic              pend_q;

  assign match   = bp_hit(bp_q, pc);
  assign clr_evt = wr_en && (wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= '0;
    end else if (wr_en) begin
      bp_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (clr_evt) begin
      pend_q <= 1'b0;
    end else if (match) begin
      pend_q <= 1'b1;
    end
  end

  assign bp_addr = bp_q;
  assign irq     = pend_q;

  AST_BKPT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match && !clr_evt |=> irq);  // R4
  AST_BKPT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_evt |=> irq);  // R4
  AST_BKPT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq && (bp_addr == '0));  // R5
  AST_BKPT_NZ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wdata != '0) && irq |=> irq);  // R6
  AST_BKPT_CPU_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_hit && !wr_en && (cpu_wdata != bp_addr) |=> $stable(bp_addr));  // R3
endmodule

// File: rtl/hpbr_route_unit.sv
module hpbr_route_unit
  import hpbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cpu_wr_hit,
  input  logic [NSRC-1:0]   src,
  output logic [DATA_W-1:0] route,
  output logic [DATA_W-1:0] status,
  output logic [NSRC-1:0]   to_cpu,
  output logic              to_host
);
  logic [DATA_W-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= ROUTE_RST;
    end else if (wr_en) begin
      route_q <= wdata & ROUTE_WMASK;
    end
  end

  assign route = route_q;

  always_comb begin
    status = '0;
    for (int s = 0; s < NSRC; s++) begin
      status[host_pos(s)] = src[s] & route_q[host_pos(s)];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      localparam int HP = host_pos(g);
      if (has_cpu_bit(g)) begin : g_pair
        localparam int CP = cpu_pos(g);
        assign to_cpu[g] = src[g] & route_q[CP];
        AST_PAIR_CPU_GATE: assert property (@(posedge clk) disable iff (!rst_n)
          to_cpu[g] |-> route[CP]);  // R8
      end else begin : g_single
        assign to_cpu[g] = src[g] & ~route_q[HP];
        AST_SINGLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
          !(to_cpu[g] && status[HP]));  // R7
      end
    end
  endgenerate

  assign to_host = |status;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    route[5:4] == 2'b00);  // R2
  AST_ROUTE_CPU_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr_hit && !wr_en |=> $stable(route));  // R3
endmodule

// File: rtl/hpbr_read_port.sv
module hpbr_read_port
  import hpbr_pkg::*;
#(
  parameter bit SHOW_STATUS = 1'b1
) (
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] bp_addr,
  input  logic [DATA_W-1:0] route,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] stat_view;

  generate
    if (SHOW_STATUS) begin : g_stat
      assign stat_view = status;
    end else begin : g_nostat
      assign stat_view = '0;
    end
  endgenerate

  always_comb begin
    case (addr)
      OFS_BKPT:  rdata = bp_addr;
      OFS_ROUTE: rdata = route;
      OFS_STAT:  rdata = stat_view;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/hpbr_top.sv
module hpbr_top
  import hpbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [1:0]        cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] cpu_pc,
  input  logic [NSRC-1:0]   src_irq,
  output logic [NSRC-1:0]   cpu_irq,
  output logic              host_irq,
  output logic              bkpt_irq
);
  logic              host_wr_bp, host_wr_rt;
  logic              cpu_wr_bp, cpu_wr_rt;
  logic [DATA_W-1:0] bp_addr, route, status;
  logic              bp_match, bp_clr;

  assign host_wr_bp = host_wr && (host_addr == OFS_BKPT);
  assign host_wr_rt = host_wr && (host_addr == OFS_ROUTE);
  assign cpu_wr_bp  = cpu_wr && (cpu_addr == OFS_BKPT);
  assign cpu_wr_rt  = cpu_wr && (cpu_addr == OFS_ROUTE);

  hpbr_bkpt_unit u_bkpt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr_bp),
    .wdata      (host_wdata),
    .cpu_wr_hit (cpu_wr_bp),
    .cpu_wdata  (cpu_wdata),
    .pc         (cpu_pc),
    .bp_addr    (bp_addr),
    .match      (bp_match),
    .clr_evt    (bp_clr),
    .irq        (bkpt_irq)
  );

  hpbr_route_unit u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr_rt),
    .wdata      (host_wdata),
    .cpu_wr_hit (cpu_wr_rt),
    .src        (src_irq),
    .route      (route),
    .status     (status),
    .to_cpu     (cpu_irq),
    .to_host    (host_irq)
  );

  hpbr_read_port #(.SHOW_STATUS(1'b1)) u_host_rd (
    .addr    (host_addr),
    .bp_addr (bp_addr),
    .route   (route),
    .status  (status),
    .rdata   (host_rdata)
  );

  hpbr_read_port #(.SHOW_STATUS(1'b0)) u_cpu_rd (
    .addr    (cpu_addr),
    .bp_addr (bp_addr),
    .route   (route),
    .status  (status),
    .rdata   (cpu_rdata)
  );

  AST_HOST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (status != '0));  // R9
  AST_MATCH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    bp_match |-> (cpu_pc == bp_addr) && (cpu_pc != '0));  // R4
  AST_CLR_ONLY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    bp_clr |-> host_wr);  // R5
endmodule

// File: tb/hpbr_top_test.sv
`timescale 1ns/1ps
module hpbr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic [1:0]  cpu_addr = 2'd0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic [15:0] cpu_pc = 16'h0;
  logic [9:0]  src_irq = 10'h0;
  logic [9:0]  cpu_irq;
  logic        host_irq;
  logic        bkpt_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  hpbr_top uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_pc(cpu_pc), .src_irq(src_irq), .cpu_irq(cpu_irq), .host_irq(host_irq),
    .bkpt_irq(bkpt_irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model of steering, written bit by bit
  function automatic logic [9:0] m_cpu(input logic [15:0] r, input logic [9:0] s);
    logic [9:0] v;
    v[0] = s[0] & ~r[1];
    v[1] = s[1] & ~r[2];
    v[2] = s[2] & ~r[3];
    v[3] = s[3] & ~r[6];
    v[4] = s[4] & ~r[7];
    v[5] = s[5] & ~r[9];
    v[6] = s[6] & r[10];
    v[7] = s[7] & r[12];
    v[8] = s[8] & ~r[14];
    v[9] = s[9] & ~r[15];
    return v;
  endfunction

  function automatic logic [15:0] m_stat(input logic [15:0] r, input logic [9:0] s);
    logic [15:0] v;
    v = 16'h0;
    v[1]  = s[0] & r[1];
    v[2]  = s[1] & r[2];
    v[3]  = s[2] & r[3];
    v[6]  = s[3] & r[6];
    v[7]  = s[4] & r[7];
    v[9]  = s[5] & r[9];
    v[11] = s[6] & r[11];
    v[13] = s[7] & r[13];
    v[14] = s[8] & r[14];
    v[15] = s[9] & r[15];
    return v;
  endfunction

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    host_read(2'd0, d); check("R1 bkpt reset", d, 16'h0000);
    host_read(2'd1, d); check("R1 route reset", d, 16'h1400);
    check("R1 bkpt_irq reset", {15'h0, bkpt_irq}, 16'h0);
  endtask

  task automatic t_host_rw();
    logic [15:0] d;
    @(negedge clk);
    host_addr = 2'd1; host_wr = 1'b1; host_wdata = 16'hFFFF; #1;
    check("R2 no early write", host_rdata, 16'h1400);
    @(negedge clk);
    host_wr = 1'b0; #1;
    check("R2 route written, rsvd zero", host_rdata, 16'hFFCF);
    host_write(2'd1, 16'h0101);
    host_read(2'd1, d); check("R2 storage bits 8/0", d, 16'h0101);
    host_write(2'd0, 16'hBEEF);
    host_read(2'd0, d); check("R2 bkpt written", d, 16'hBEEF);
  endtask

  task automatic t_cpu_ignored();
    logic [15:0] d;
    @(negedge clk);
    cpu_addr = 2'd0; cpu_wr = 1'b1; cpu_wdata = 16'h1234;
    @(negedge clk);
    cpu_addr = 2'd1; cpu_wdata = 16'hFFFF;
    @(negedge clk);
    cpu_wr = 1'b0;
    host_read(2'd0, d); check("R3 bkpt untouched by cpu", d, 16'hBEEF);
    host_read(2'd1, d); check("R3 route untouched by cpu", d, 16'h0101);
    cpu_addr = 2'd0; #1; check("R3 cpu reads bkpt", cpu_rdata, 16'hBEEF);
    cpu_addr = 2'd1; #1; check("R3 cpu reads route", cpu_rdata, 16'h0101);
  endtask

  task automatic t_bkpt();
    host_write(2'd0, 16'h0400);
    cpu_pc = 16'h0400; #1;
    check("R4 not before edge", {15'h0, bkpt_irq}, 16'h0);
    @(negedge clk);
    check("R4 raised after match", {15'h0, bkpt_irq}, 16'h1);
    cpu_pc = 16'h0402;
    @(negedge clk); @(negedge clk);
    check("R4 sticky after pc moves", {15'h0, bkpt_irq}, 16'h1);
    host_write(2'd0, 16'h0800);
    check("R6 nonzero write keeps pending", {15'h0, bkpt_irq}, 16'h1);
    host_write(2'd0, 16'h0000);
    check("R5 zero write clears", {15'h0, bkpt_irq}, 16'h0);
    cpu_pc = 16'h0000;
    @(negedge clk); @(negedge clk);
    check("R5 disarmed at pc 0", {15'h0, bkpt_irq}, 16'h0);
  endtask

  task automatic t_route(input logic [15:0] r, input logic [9:0] s, input string tag);
    logic [15:0] d;
    host_write(2'd1, r);
    src_irq = s;
    host_read(2'd2, d);
    check({tag, " cpu_irq"}, {6'h0, cpu_irq}, {6'h0, m_cpu(r & 16'hFFCF, s)});
    check({"R9 status ", tag}, d, m_stat(r & 16'hFFCF, s));
    check({"R9 host_irq ", tag}, {15'h0, host_irq}, {15'h0, |m_stat(r & 16'hFFCF, s)});
  endtask

  task automatic t_unmapped();
    src_irq = 10'h3FF;
    host_addr = 2'd3; cpu_addr = 2'd3; #1;
    check("R10 host offset 3", host_rdata, 16'h0);
    check("R10 cpu offset 3", cpu_rdata, 16'h0);
    cpu_addr = 2'd2; #1;
    check("R10 cpu status hidden", cpu_rdata, 16'h0);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_rw();
    t_cpu_ignored();
    t_bkpt();
    t_route(16'h1400, 10'h3FF, "R7 default all to cpu");
    t_route(16'hFFFF, 10'h3FF, "R7 all to host");
    t_route(16'hC2CE, 10'h155, "R7 singles to host");
    t_route(16'h2800, 10'h3FF, "R8 sof host only");
    t_route(16'h3C00, 10'h0C0, "R8 sof both sides");
    t_route(16'h0000, 10'h0C0, "R8 sof neither");
    t_route(16'h8000, 10'h200, "R9 vbus only");
    t_route(16'h8000, 10'h000, "R9 quiet");
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule